// File: doc/BRIEF.md
# Per-Timeslot Channel Groomer

This block sits between a channelized serial line port and a multi-channel HDLC controller. It handles the line one bit per clock. An 8-bit timeslot, sent most significant bit first, is made of eight consecutive clocks. A frame is `NUM_SLOTS` timeslots. A table holds one configuration word per timeslot. For each slot that word sets the data rate, a transmit fill of ones, local and network loopback, the HDLC channel number the slot is tagged with, and whether the slot is routed to or from a shared bit-error test engine and a receive loop-code detector.

A frame-sync pulse marks the last bit of a frame, so the following clock is bit 0 of slot 0. Without a pulse, the slot counter wraps after the last slot on its own. The configuration for each slot is fetched one clock before the slot begins and is held for all eight bits of the slot. A table write therefore takes effect the next time the written slot comes around. A port-wide fast mode bypasses the table, passes every bit straight through, and tags all traffic with one fixed channel number.

Top module: `slot_groomer`

## Requirements
- R1: While reset is held, and after reset with an untouched table, every slot is off: `hdlcRxValid` and `hdlcTxReq` are 0 and `lineTxBit` is 1.
- R2: The clock after `fsync` is high is bit 0 of slot 0. A slot lasts 8 clocks, and slot `NUM_SLOTS-1` is followed by slot 0. `hdlcChan` shows the channel field (word bits 7:0) of the current slot's configuration.
- R3: Rate field (word bits 9:8) 2 or 3 is full rate. All 8 bits are strobed: `hdlcRxBit` equals the receive source, `hdlcTxReq` is 1 and `lineTxBit` equals `hdlcTxBit`.
- R4: Rate field 1 is reduced rate. Bits 0 to 6 behave as at full rate. On bit 7 (the LSB) both strobes are 0 and the transmit bit is 1.
- R5: Rate field 0 is off. Both strobes are 0 and the transmit bit is 1 on all 8 bits.
- R6: Fill (bit 10) makes the transmit bit 1 and holds `hdlcTxReq` at 0. The receive direction is unchanged.
- R7: Local loopback (bit 11) makes the HDLC receive source the slot's transmit bit instead of `lineRxBit`. The line transmit is unchanged.
- R8: Network loopback (bit 12) drives `lineTxBit` from `lineRxBit` on every bit of the slot, whatever the rate or fill.
- R9: Test transmit (bit 13) sources the slot's transmit data bits from `testTxBit` and holds `hdlcTxReq` at 0. Test receive (bit 14) raises `testRxValid` on the slot's data bits, with `testRxBit` set to the receive source.
- R10: Loop detect (bit 15) raises `loopDetValid` on the slot's data bits, with `loopDetBit` equal to `lineRxBit`.
- R11: With `fastMode` high, every bit is strobed both ways, with `hdlcRxBit`=`lineRxBit` and `lineTxBit`=`hdlcTxBit`. Both taps are idle and `hdlcChan`=`FAST_CHAN`.
- R12: A slot's configuration is latched when the slot starts. A write during the slot changes nothing until that slot's next occurrence. Every data output (`hdlcRxBit`, `testRxBit`, `loopDetBit`) reads 0 while its strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rstN | input | 1 | Active-low synchronous reset |
| fsync | input | 1 | High on the last bit of a frame |
| fastMode | input | 1 | Unchannelized pass-through mode |
| cfgWe | input | 1 | Table write enable |
| cfgSlot | input | SLOT_W | Table entry to write |
| cfgWord | input | 16 | Configuration word |
| lineRxBit | input | 1 | Receive bit from the line |
| lineTxBit | output | 1 | Transmit bit to the line |
| hdlcRxBit | output | 1 | Receive bit to the HDLC side |
| hdlcRxValid | output | 1 | Receive bit strobe |
| hdlcTxBit | input | 1 | Transmit bit from the HDLC side |
| hdlcTxReq | output | 1 | HDLC transmit bit consumed this clock |
| hdlcChan | output | 8 | Channel tag of the current slot |
| testTxBit | input | 1 | Transmit bit from the test engine |
| testRxBit | output | 1 | Receive bit to the test engine |
| testRxValid | output | 1 | Test receive strobe |
| loopDetBit | output | 1 | Receive bit to the loop-code detector |
| loopDetValid | output | 1 | Loop-detector strobe |

## Verification
The bench builds the block with `NUM_SLOTS`=5 and `FAST_CHAN`=42. Five is not a power of two, so the counter wrap has to come from the slot limit and not from a counter overflow. A frame is also only 40 clocks long, so the run covers many frames, many table rewrites and many mid-frame resynchronisations. Because `FAST_CHAN` differs from every channel the directed setup uses, a wrong tag in fast mode shows up at once.

// File: rtl/sg_pkg.sv
package sg_pkg;
  localparam int CHAN_W = 8;

  typedef enum logic [1:0] {
    RATE_OFF = 2'd0,
    RATE_56  = 2'd1,
    RATE_64  = 2'd2,
    RATE_64B = 2'd3
  } rate_e;

  typedef struct packed {
    logic              loopDet;
    logic              testRx;
    logic              testTx;
    logic              netLoop;
    logic              localLoop;
    logic              fill;
    rate_e             rate;
    logic [CHAN_W-1:0] chan;
  } slot_cfg_t;

  localparam int CFG_W = $bits(slot_cfg_t);

  typedef struct packed {
    logic dataBit;
    logic fill;
    logic localLoop;
    logic netLoop;
    logic testTx;
    logic testRx;
    logic loopDet;
    logic fast;
  } groom_ctl_t;
endpackage

// File: rtl/sg_control.sv
module sg_control
  import sg_pkg::*;
#(
  parameter int NUM_SLOTS = 32,
  parameter logic [CHAN_W-1:0] FAST_CHAN = 8'd1,
  localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fsync,
  input  logic              fastMode,
  input  logic              cfgWe,
  input  logic [SLOT_W-1:0] cfgSlot,
  input  logic [CFG_W-1:0]  cfgWord,
  output groom_ctl_t        ctl,
  output logic [CHAN_W-1:0] chanTag
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);
  localparam logic [2:0] LAST_BIT = 3'd7;

  slot_cfg_t        table_q [NUM_SLOTS];
  slot_cfg_t        cfgQ;
  logic [2:0]       bitCnt;
  logic [SLOT_W-1:0] slotCnt;
  logic [SLOT_W-1:0] nextSlot;
  logic             slotEnd;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rstN) table_q[g] <= '0;
      else if (cfgWe && cfgSlot == SLOT_W'(g)) table_q[g] <= slot_cfg_t'(cfgWord);
    end
  end

  assign slotEnd  = fsync || (bitCnt == LAST_BIT);
  assign nextSlot = (fsync || slotCnt == LAST_SLOT) ? '0 : slotCnt + 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCnt  <= '0;
      slotCnt <= '0;
      cfgQ    <= '0;
    end else if (slotEnd) begin
      bitCnt  <= '0;
      slotCnt <= nextSlot;
      cfgQ    <= table_q[nextSlot];
    end else begin
      bitCnt  <= bitCnt + 3'd1;
    end
  end

  always_comb begin
    ctl           = '0;
    ctl.fast      = fastMode;
    if (fastMode) begin
      ctl.dataBit = 1'b1;
    end else begin
      ctl.dataBit   = (cfgQ.rate != RATE_OFF) &&
                      !(cfgQ.rate == RATE_56 && bitCnt == LAST_BIT);
      ctl.fill      = cfgQ.fill;
      ctl.localLoop = cfgQ.localLoop;
      ctl.netLoop   = cfgQ.netLoop;
      ctl.testTx    = cfgQ.testTx;
      ctl.testRx    = cfgQ.testRx;
      ctl.loopDet   = cfgQ.loopDet;
    end
    chanTag = fastMode ? FAST_CHAN : cfgQ.chan;
  end

  assert_frame_restart_R2: assert property (@(posedge clk) disable iff (!rstN)
    fsync |=> (bitCnt == 3'd0 && slotCnt == '0));
  assert_slot_wrap_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!fsync && bitCnt == LAST_BIT && slotCnt == LAST_SLOT) |=> (slotCnt == '0));
  assert_bit_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!fsync && bitCnt != LAST_BIT) |=> (bitCnt == $past(bitCnt) + 3'd1 && $stable(slotCnt)));
  assert_cfg_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    (!fsync && bitCnt != LAST_BIT) |=> $stable(cfgQ));
endmodule

// File: rtl/sg_datapath.sv
module sg_datapath
  import sg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  groom_ctl_t ctl,
  input  logic       lineRxBit,
  input  logic       hdlcTxBit,
  input  logic       testTxBit,
  output logic       lineTxBit,
  output logic       hdlcRxBit,
  output logic       hdlcRxValid,
  output logic       hdlcTxReq,
  output logic       testRxBit,
  output logic       testRxValid,
  output logic       loopDetBit,
  output logic       loopDetValid
);
  logic txPayload;
  logic txGroomed;
  logic rxSource;

  always_comb begin
    txPayload = ctl.testTx ? testTxBit : hdlcTxBit;
    txGroomed = (ctl.dataBit && !ctl.fill) ? txPayload : 1'b1;
    rxSource  = ctl.localLoop ? txGroomed : lineRxBit;
    if (ctl.fast) begin
      lineTxBit    = hdlcTxBit;
      hdlcRxValid  = 1'b1;
      hdlcRxBit    = lineRxBit;
      hdlcTxReq    = 1'b1;
      testRxValid  = 1'b0;
      testRxBit    = 1'b0;
      loopDetValid = 1'b0;
      loopDetBit   = 1'b0;
    end else begin
      lineTxBit    = ctl.netLoop ? lineRxBit : txGroomed;
      hdlcRxValid  = ctl.dataBit;
      hdlcRxBit    = ctl.dataBit & rxSource;
      hdlcTxReq    = ctl.dataBit && !ctl.fill && !ctl.testTx;
      testRxValid  = ctl.dataBit && ctl.testRx;
      testRxBit    = testRxValid & rxSource;
      loopDetValid = ctl.dataBit && ctl.loopDet;
      loopDetBit   = loopDetValid & lineRxBit;
    end
  end

  assert_fill_ones_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.fill && !ctl.netLoop && !ctl.fast) |-> (lineTxBit && !hdlcTxReq));
  assert_net_loop_R8: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.netLoop && !ctl.fast) |-> (lineTxBit == lineRxBit));
  assert_idle_bit_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.dataBit && !ctl.fast) |-> (!hdlcRxValid && !hdlcTxReq && !testRxValid && !loopDetValid));
  assert_fast_pass_R11: assert property (@(posedge clk) disable iff (!rstN)
    ctl.fast |-> (hdlcRxValid && hdlcTxReq && !testRxValid && !loopDetValid
                  && lineTxBit == hdlcTxBit));
endmodule

// File: rtl/slot_groomer.sv
module slot_groomer
  import sg_pkg::*;
#(
  parameter int NUM_SLOTS = 32,
  parameter logic [CHAN_W-1:0] FAST_CHAN = 8'd1,
  localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fsync,
  input  logic              fastMode,
  input  logic              cfgWe,
  input  logic [SLOT_W-1:0] cfgSlot,
  input  logic [CFG_W-1:0]  cfgWord,
  input  logic              lineRxBit,
  output logic              lineTxBit,
  output logic              hdlcRxBit,
  output logic              hdlcRxValid,
  input  logic              hdlcTxBit,
  output logic              hdlcTxReq,
  output logic [CHAN_W-1:0] hdlcChan,
  input  logic              testTxBit,
  output logic              testRxBit,
  output logic              testRxValid,
  output logic              loopDetBit,
  output logic              loopDetValid
);
  groom_ctl_t ctl;

  sg_control #(.NUM_SLOTS(NUM_SLOTS), .FAST_CHAN(FAST_CHAN)) control_i (
    .clk(clk), .rstN(rstN), .fsync(fsync), .fastMode(fastMode),
    .cfgWe(cfgWe), .cfgSlot(cfgSlot), .cfgWord(cfgWord),
    .ctl(ctl), .chanTag(hdlcChan)
  );

  sg_datapath datapath_i (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .lineRxBit(lineRxBit), .hdlcTxBit(hdlcTxBit), .testTxBit(testTxBit),
    .lineTxBit(lineTxBit), .hdlcRxBit(hdlcRxBit), .hdlcRxValid(hdlcRxValid),
    .hdlcTxReq(hdlcTxReq), .testRxBit(testRxBit), .testRxValid(testRxValid),
    .loopDetBit(loopDetBit), .loopDetValid(loopDetValid)
  );
endmodule

// File: tb/slot_groomer_tb.sv
module slot_groomer_tb_top;
  import sg_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 5;
  localparam int SW = $clog2(NS);
  localparam logic [7:0] FCHAN = 8'd42;

  logic clk = 1'b0, rstN = 1'b0, fsync = 1'b0, fastMode = 1'b0, cfgWe = 1'b0;
  logic [SW-1:0] cfgSlot = '0;
  logic [CFG_W-1:0] cfgWord = '0;
  logic lineRxBit = 1'b0, hdlcTxBit = 1'b0, testTxBit = 1'b0;
  logic lineTxBit, hdlcRxBit, hdlcRxValid, hdlcTxReq, testRxBit, testRxValid;
  logic loopDetBit, loopDetValid;
  logic [7:0] hdlcChan;

  int checks = 0, failures = 0;
  slot_cfg_t tbl [NS];
  slot_cfg_t cur;
  int bitPos = 0, slotPos = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  slot_groomer #(.NUM_SLOTS(NS), .FAST_CHAN(FCHAN)) dut_i (
    .clk(clk), .rstN(rstN), .fsync(fsync), .fastMode(fastMode), .cfgWe(cfgWe),
    .cfgSlot(cfgSlot), .cfgWord(cfgWord), .lineRxBit(lineRxBit), .lineTxBit(lineTxBit),
    .hdlcRxBit(hdlcRxBit), .hdlcRxValid(hdlcRxValid), .hdlcTxBit(hdlcTxBit),
    .hdlcTxReq(hdlcTxReq), .hdlcChan(hdlcChan), .testTxBit(testTxBit),
    .testRxBit(testRxBit), .testRxValid(testRxValid), .loopDetBit(loopDetBit),
    .loopDetValid(loopDetValid));

  function automatic slot_cfg_t mk(input logic [1:0] rate, input logic fl, input logic ll,
      input logic nl, input logic ttx, input logic trx, input logic ld, input logic [7:0] ch);
    return slot_cfg_t'({ld, trx, ttx, nl, ll, fl, rate, ch});
  endfunction

  // expected {rxV, rxB, txReq, lineTx, testV, testB, ldV, ldB}
  function automatic logic [7:0] model(input slot_cfg_t c, input int b, input logic fast,
                                       input logic lr, input logic ht, input logic tt);
    logic dat, grm, src, tv, lv;
    if (fast) return {1'b1, lr, 1'b1, ht, 4'b0000};
    dat = (c.rate != 2'd0) && !(c.rate == 2'd1 && b == 7);
    grm = (dat && !c.fill) ? (c.testTx ? tt : ht) : 1'b1;
    src = c.localLoop ? grm : lr;
    tv  = dat && c.testRx;
    lv  = dat && c.loopDet;
    return {dat, dat & src, dat && !c.fill && !c.testTx, c.netLoop ? lr : grm,
            tv, tv & src, lv, lv & lr};
  endfunction

  function automatic string tagOf(input slot_cfg_t c, input logic fast);
    if (fast) return "R11";
    if (c.netLoop) return "R8";
    if (c.localLoop) return "R7";
    if (c.testTx || c.testRx) return "R9";
    if (c.loopDet) return "R10";
    if (c.fill) return "R6";
    if (c.rate == 2'd0) return "R5";
    if (c.rate == 2'd1) return "R4";
    return "R3";
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s slot=%0d bit=%0d actual=%b expected=%b", tag, slotPos, bitPos, act, exp);
    end
  endtask

  task automatic step(input logic fs, input logic we, input int ws, input slot_cfg_t wd,
                      input string lbl);
    logic [7:0] exp, act;
    string tag;
    int nxt;
    @(negedge clk);
    fsync = fs; cfgWe = we; cfgSlot = SW'(ws); cfgWord = wd;
    lineRxBit = 1'($urandom); hdlcTxBit = 1'($urandom); testTxBit = 1'($urandom);
    #1;
    exp = model(cur, bitPos, fastMode, lineRxBit, hdlcTxBit, testTxBit);
    act = {hdlcRxValid, hdlcRxBit, hdlcTxReq, lineTxBit, testRxValid, testRxBit,
           loopDetValid, loopDetBit};
    tag = (lbl != "") ? lbl : tagOf(cur, fastMode);
    check(tag, act, exp);
    check("R2", {hdlcChan}, fastMode ? FCHAN : cur.chan);
    if (fs || bitPos == 7) begin
      nxt = (fs || slotPos == NS - 1) ? 0 : slotPos + 1;
      cur = tbl[nxt];
      slotPos = nxt;
      bitPos = 0;
    end else bitPos++;
    if (we) tbl[ws] = wd;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < NS; i++) tbl[i] = '0;
    cur = '0;
    // R1: reset state
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); #1;
      check("R1", {hdlcRxValid, hdlcTxReq, lineTxBit}, 3'b001);
    end
    @(negedge clk); rstN = 1'b1;
    #1; check("R1", {hdlcRxValid, hdlcTxReq, lineTxBit}, 3'b001);
    // directed table
    step(0, 1, 0, mk(2'd2, 0, 0, 0, 0, 0, 0, 8'd3), "R1");
    step(0, 1, 1, mk(2'd1, 0, 0, 0, 0, 0, 0, 8'd9), "R1");
    step(0, 1, 2, mk(2'd0, 0, 0, 0, 0, 0, 0, 8'd4), "R1");
    step(0, 1, 3, mk(2'd2, 1, 1, 0, 0, 0, 0, 8'd12), "R1");
    step(0, 1, 4, mk(2'd1, 0, 0, 1, 0, 1, 1, 8'd20), "R1");
    step(1, 0, 0, '0, "R2");
    for (int i = 0; i < 2 * NS * 8; i++) step(0, 0, 0, '0, "");
    // second directed set: test transmit, local loop at reduced rate, fill with net loop
    step(0, 1, 0, mk(2'd3, 0, 0, 0, 1, 0, 0, 8'd5), "");
    step(0, 1, 2, mk(2'd1, 0, 1, 0, 0, 1, 0, 8'd6), "");
    step(0, 1, 3, mk(2'd2, 1, 0, 1, 0, 0, 1, 8'd7), "");
    while (!(slotPos == NS - 1 && bitPos == 7)) step(0, 0, 0, '0, "");
    step(1, 0, 0, '0, "R2");
    for (int i = 0; i < NS * 8; i++) step(0, 0, 0, '0, "");
    // R12: rewrite slot 1 mid-slot; old config must hold for the rest of the slot
    while (!(slotPos == 1 && bitPos == 3)) step(0, 0, 0, '0, "");
    step(0, 1, 1, mk(2'd0, 0, 0, 0, 0, 0, 0, 8'd77), "R12");
    while (slotPos == 1) step(0, 0, 0, '0, "R12");
    while (slotPos != 1) step(0, 0, 0, '0, "");
    for (int i = 0; i < 8; i++) step(0, 0, 0, '0, "R12");
    // R11: fast mode directed
    fastMode = 1'b1;
    for (int i = 0; i < 20; i++) step(0, 0, 0, '0, "R11");
    fastMode = 1'b0;
    // constrained random
    for (int f = 0; f < 60; f++) begin
      fastMode = ($urandom_range(9) == 0);
      for (int i = 0; i < NS * 8; i++) begin
        logic fs, we;
        int ws;
        fs = ($urandom_range(199) == 0) ||
             (i == NS * 8 - 1 && $urandom_range(1) == 1);
        we = ($urandom_range(5) == 0);
        ws = $urandom_range(NS - 1);
        step(fs, we, ws, slot_cfg_t'(16'($urandom)), "");
      end
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule